// File: doc/BRIEF.md
# ADC Conversion Start Trigger Selector

This block decides the clock cycle in which an analog-to-digital conversion is allowed to begin. A two-bit source field picks a trigger path. One path watches the compare-match flags of four timer channels, each with its own enable. The other watches an external trigger line, taken from one of two port pins. A start is issued only when the chosen path sees a qualifying edge and the conversion-armed bit is set. The output is a one-clock pulse on `start_pulse`.

On the timer path, the block registers the compare flags. A start is produced when an enabled flag goes from 0 to 1 between two consecutive samples. On the external path, the selected pin is registered, and a start is produced on a high-to-low change. This only happens while the pin's interrupt-input enable is set and the chosen port's direction bit marks it as an input. If the source field or the pin routing changes, the edge history in that cycle is treated as stale. No edge is reported across such a change.

Top module: `adc_trig_sel`

## Requirements
- R1: `start_pulse` is a registered, one-cycle pulse. It goes high in the cycle after the clock edge at which a qualifying edge is first visible at the inputs.
- R2: With `src_sel` = 2'b10 (timer path), a 0-to-1 change of `cmp_flag[i]` between two consecutive clock samples produces a start. A 1-to-0 change or a steady level does not.
- R3: `cmp_flag[i]` can only cause a start while `cmp_en[i]` is 1. Bit 0 is channel A and bit 3 is channel D.
- R4: With `src_sel` = 2'b11 (external path), a 1-to-0 change of the routed trigger pin between two samples produces a start. A 0-to-1 change does not.
- R5: The external path produces no start while `pin_irq_en` is 0.
- R6: `pin_sel` = 0 routes `pin_port_a` and qualifies it with `dir_a`. `pin_sel` = 1 routes `pin_port_b` with `dir_b`. The routed pin counts only when its direction bit is 0 (input). The pin that is not selected has no effect.
- R7: No start is produced while `armed` is 0, on either path.
- R8: With `src_sel` = 2'b00 or 2'b01, no start is produced. On the timer path, the external pin is ignored. On the external path, the timer flags are ignored.
- R9: Several qualifying edges in the same cycle produce a single one-cycle pulse.
- R10: In a cycle where `src_sel` or `pin_sel` differs from its value at the previous clock edge, no start is produced. Edge history restarts from the current levels.
- R11: While `rst` is high, `start_pulse` is 0 at the next edge. Edge history is loaded with the current input levels, so levels already present at the release of reset produce no start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Trigger source: 00/01 none, 10 timer, 11 external |
| armed | input | 1 | Conversion-start armed bit |
| cmp_flag | input | 4 | Timer compare-match flags, bit 0 = channel A |
| cmp_en | input | 4 | Per-channel trigger enable |
| pin_port_a | input | 1 | External trigger candidate on port A |
| pin_port_b | input | 1 | External trigger candidate on port B |
| pin_sel | input | 1 | 0 routes port A, 1 routes port B |
| dir_a | input | 1 | Port A direction bit, 0 = input |
| dir_b | input | 1 | Port B direction bit, 0 = input |
| pin_irq_en | input | 1 | Interrupt-input enable for the trigger pin |
| start_pulse | output | 1 | One-cycle conversion start pulse |

## Verification
The hardest case to reach is a change of source or routing that lands in the same cycle as a level difference that would otherwise look like an edge. Examples are switching `pin_sel` to a port that sits low while the old port sat high, and switching back to the timer path while a flag rises. The stimulus table builds those prior levels on purpose over earlier rows, then changes the select and the level together in one row. A directed step also raises a flag in the same cycle as reset, to show that the reset history load swallows it.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int unsigned NUM_CH  = 4;
    localparam int unsigned SRC_W   = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE0 = 2'b00,
        SRC_NONE1 = 2'b01,
        SRC_TIMER = 2'b10,
        SRC_EXT   = 2'b11
    } src_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    typedef struct packed {
        logic level;
        logic usable;
    } pin_t;

    function automatic logic any_enabled(input logic [NUM_CH-1:0] hits,
                                         input logic [NUM_CH-1:0] en);
        return |(hits & en);
    endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_trig_pkg::*;
#(
    parameter int unsigned W   = 1,
    parameter edge_e       POL = EDGE_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         resync,
    input  logic [W-1:0] din,
    output logic [W-1:0] hit
);

    logic [W-1:0] prev_q;
    logic [W-1:0] raw;

    // History always follows the input; reset simply reloads current levels.
    always_ff @(posedge clk) begin
        prev_q <= din;
    end

    generate
        if (POL == EDGE_RISE) begin : g_rise
            assign raw = din & ~prev_q;
        end else begin : g_fall
            assign raw = prev_q & ~din;
        end
    endgenerate

    assign hit = (resync || rst) ? '0 : raw;

endmodule

// File: rtl/adc_trig_pin_route.sv
module adc_trig_pin_route
    import adc_trig_pkg::*;
(
    input  logic pin_port_a,
    input  logic pin_port_b,
    input  logic pin_sel,
    input  logic dir_a,
    input  logic dir_b,
    input  logic pin_irq_en,
    output pin_t pin
);

    always_comb begin
        pin.level  = pin_sel ? pin_port_b : pin_port_a;
        pin.usable = pin_irq_en && !(pin_sel ? dir_b : dir_a);
    end

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic              armed,
    input  logic [NUM_CH-1:0] cmp_flag,
    input  logic [NUM_CH-1:0] cmp_en,
    input  logic              pin_port_a,
    input  logic              pin_port_b,
    input  logic              pin_sel,
    input  logic              dir_a,
    input  logic              dir_b,
    input  logic              pin_irq_en,
    output logic              start_pulse
);

    logic [SRC_W-1:0]  src_q;
    logic              psel_q;
    logic              cfg_changed;
    logic [NUM_CH-1:0] tmr_rise;
    logic              pin_fall;
    pin_t              pin;
    logic              tmr_hit;
    logic              ext_hit;
    logic              start_d;
    logic              start_q;

    always_ff @(posedge clk) begin
        src_q  <= src_sel;
        psel_q <= pin_sel;
    end

    assign cfg_changed = (src_sel != src_q) || (pin_sel != psel_q);

    adc_trig_pin_route u_route (
        .pin_port_a (pin_port_a),
        .pin_port_b (pin_port_b),
        .pin_sel    (pin_sel),
        .dir_a      (dir_a),
        .dir_b      (dir_b),
        .pin_irq_en (pin_irq_en),
        .pin        (pin)
    );

    adc_trig_edge #(.W(NUM_CH), .POL(EDGE_RISE)) u_tmr_edge (
        .clk    (clk),
        .rst    (rst),
        .resync (cfg_changed),
        .din    (cmp_flag),
        .hit    (tmr_rise)
    );

    adc_trig_edge #(.W(1), .POL(EDGE_FALL)) u_pin_edge (
        .clk    (clk),
        .rst    (rst),
        .resync (cfg_changed),
        .din    (pin.level),
        .hit    (pin_fall)
    );

    assign tmr_hit = any_enabled(tmr_rise, cmp_en);
    assign ext_hit = pin_fall && pin.usable;

    always_comb begin
        start_d = 1'b0;
        case (src_e'(src_sel))
            SRC_TIMER: start_d = tmr_hit;
            SRC_EXT:   start_d = ext_hit;
            default:   start_d = 1'b0;
        endcase
        start_d = start_d && armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start_d;
        end
    end

    assign start_pulse = start_q;

endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk
    import adc_trig_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SRC_W-1:0]  src_sel,
    input logic              armed,
    input logic [NUM_CH-1:0] cmp_flag,
    input logic [NUM_CH-1:0] cmp_en,
    input logic              pin_sel,
    input logic              dir_a,
    input logic              dir_b,
    input logic              pin_irq_en,
    input logic              start_pulse
);

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> !start_pulse);

    a_r7_needs_armed: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(armed));

    a_r8_source_valid: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(src_sel[1]));

    a_r10_no_change: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> ($past(src_sel) == $past(src_sel, 2)) &&
                        ($past(pin_sel) == $past(pin_sel, 2)));

    a_r5_ext_qualified: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && $past(src_sel) == SRC_EXT) |->
            ($past(pin_irq_en) && !($past(pin_sel) ? $past(dir_b) : $past(dir_a))));

    a_r3_timer_enabled_rise: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && $past(src_sel) == SRC_TIMER) |->
            (($past(cmp_flag & cmp_en) & ~$past(cmp_flag, 2)) != '0));

endmodule

bind adc_trig_sel adc_trig_sel_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .src_sel     (src_sel),
    .armed       (armed),
    .cmp_flag    (cmp_flag),
    .cmp_en      (cmp_en),
    .pin_sel     (pin_sel),
    .dir_a       (dir_a),
    .dir_b       (dir_b),
    .pin_irq_en  (pin_irq_en),
    .start_pulse (start_pulse)
);

// File: tb/adc_trig_sel_tb.sv
module adc_trig_sel_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] src_sel;
    logic       armed;
    logic [3:0] cmp_flag;
    logic [3:0] cmp_en;
    logic       pin_port_a;
    logic       pin_port_b;
    logic       pin_sel;
    logic       dir_a;
    logic       dir_b;
    logic       pin_irq_en;
    logic       start_pulse;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    adc_trig_sel u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_sel     (src_sel),
        .armed       (armed),
        .cmp_flag    (cmp_flag),
        .cmp_en      (cmp_en),
        .pin_port_a  (pin_port_a),
        .pin_port_b  (pin_port_b),
        .pin_sel     (pin_sel),
        .dir_a       (dir_a),
        .dir_b       (dir_b),
        .pin_irq_en  (pin_irq_en),
        .start_pulse (start_pulse)
    );

    // {src[1:0], armed, flag[3:0], en[3:0], pa, pb, psel, da, db, ien, expected}
    localparam int NV = 37;
    localparam logic [17:0] TBL [0:NV-1] = '{
        {2'b10, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 0 idle
        {2'b10, 1'b1, 4'b0001, 4'b1111, 6'b110001, 1'b1}, // 1 R2 rise A
        {2'b10, 1'b1, 4'b0001, 4'b1111, 6'b110001, 1'b0}, // 2 R1 single
        {2'b10, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 3 R2 fall
        {2'b10, 1'b1, 4'b0010, 4'b1101, 6'b110001, 1'b0}, // 4 R3 B off
        {2'b10, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 5
        {2'b10, 1'b1, 4'b0110, 4'b1111, 6'b110001, 1'b1}, // 6 R9 merge
        {2'b10, 1'b0, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 7
        {2'b10, 1'b0, 4'b1000, 4'b1111, 6'b110001, 1'b0}, // 8 R7 disarmed
        {2'b10, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 9
        {2'b00, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 10
        {2'b00, 1'b1, 4'b0001, 4'b1111, 6'b110001, 1'b0}, // 11 R8 src 00
        {2'b01, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 12
        {2'b01, 1'b1, 4'b0010, 4'b1111, 6'b110001, 1'b0}, // 13 R8 src 01
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 14
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b010001, 1'b1}, // 15 R4 fall A
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b010001, 1'b0}, // 16
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 17 R4 rise
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b010000, 1'b0}, // 18 R5 ien=0
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 19
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b010101, 1'b0}, // 20 R6 dir_a=1
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b110001, 1'b0}, // 21
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b001001, 1'b0}, // 22 R10 psel
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b011001, 1'b0}, // 23
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b001001, 1'b1}, // 24 R6 fall B
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b011011, 1'b0}, // 25
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b001011, 1'b0}, // 26 R6 dir_b=1
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b011001, 1'b0}, // 27
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b111001, 1'b0}, // 28
        {2'b11, 1'b1, 4'b0001, 4'b1111, 6'b011001, 1'b0}, // 29 R6/R8 ignored
        {2'b10, 1'b1, 4'b0000, 4'b1111, 6'b011001, 1'b0}, // 30
        {2'b10, 1'b1, 4'b0001, 4'b1111, 6'b011001, 1'b1}, // 31 R2
        {2'b10, 1'b1, 4'b0001, 4'b1111, 6'b001001, 1'b0}, // 32 R8 pin in timer
        {2'b11, 1'b1, 4'b0000, 4'b1111, 6'b001001, 1'b0}, // 33
        {2'b10, 1'b1, 4'b0001, 4'b1111, 6'b001001, 1'b0}, // 34 R10 src change
        {2'b10, 1'b1, 4'b0000, 4'b1111, 6'b001001, 1'b0}, // 35
        {2'b10, 1'b1, 4'b1000, 4'b1111, 6'b001001, 1'b1}  // 36 R3 ch D
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: start_pulse=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [17:0] v);
        src_sel    = v[17:16];
        armed      = v[15];
        cmp_flag   = v[14:11];
        cmp_en     = v[10:7];
        pin_port_a = v[6];
        pin_port_b = v[5];
        pin_sel    = v[4];
        dir_a      = v[3];
        dir_b      = v[2];
        pin_irq_en = v[1];
    endtask

    initial begin
        rst = 1'b1;
        apply(TBL[0]);
        repeat (3) @(negedge clk);
        check(start_pulse, 1'b0, "R11 reset");
        rst = 1'b0;
        @(negedge clk);
        check(start_pulse, 1'b0, "R11 release");

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(negedge clk);
            check(start_pulse, TBL[i][0], $sformatf("R1 row %0d", i));
        end

        // R11: flag rises in the same cycle reset is asserted
        apply(TBL[0]);
        @(negedge clk);
        rst = 1'b1;
        cmp_flag = 4'b0100;
        @(negedge clk);
        check(start_pulse, 1'b0, "R11 edge during reset");
        rst = 1'b0;
        @(negedge clk);
        check(start_pulse, 1'b0, "R11 level at release");
        cmp_flag = 4'b0000;
        @(negedge clk);
        cmp_flag = 4'b0100;
        @(negedge clk);
        check(start_pulse, 1'b1, "R2 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule